// File: doc/BRIEF.md
# Tapped 24-Stage Binary Divider with Split Test Mode

This block is a long binary divider. It has twenty-four divide-by-two stages, which together count up to 2^24 input clocks. Only the top seven stages are visible. They appear on a seven-bit tap bus, and stage n of the chain toggles once every 2^(n-1) input clocks. The count advances on the falling edge of the input clock. An active-low reset clears every stage. The same reset also drops an oscillator-enable output, so the clock source can be shut down while the block is held.

Exercising the upper stages from zero in normal use takes millions of clocks. For that reason, the stage chain can be split at reset into three equal sections. In split mode each section counts directly on every clock, rather than waiting for a carry from the section below it, so the taps move within a few hundred clocks. The stage count, the section count and the tap width are parameters. The defaults are 24 stages, 3 sections and 7 taps.

Top module: `binary_divider_taps`

## Requirements
- R1: In chained mode the stages hold one binary count of the falling edges seen since reset was released, modulo 2^STAGES. `taps[k]` shows count bit STAGES-TAPS+k, so `taps[0]` is stage 18 and `taps[6]` is stage 24 at the defaults.
- R2: The count changes only on a falling clock edge. The first falling edge after `rst_n` returns high is the first edge counted.
- R3: While `rst_n` is low, every falling edge clears all stages. From the edge after reset was sampled low, `taps` reads all zeros.
- R4: `osc_en` is low whenever `rst_n` is low and high whenever `rst_n` is high. It needs no clock edge.
- R5: In split mode each of the SECTIONS sections of STAGES/SECTIONS stages adds one on every falling edge, modulo its own size. At the defaults, `taps[0]` reads 1 after 2 edges and `taps` returns to 0 after 256 edges.
- R6: The mode is taken from `test_sel` at each falling edge while `rst_n` is low. `test_sel`=1 selects split mode and 0 selects chained mode. The value at the last such edge applies.
- R7: A change of `test_sel` while `rst_n` is high has no effect on the count until the next reset.
- R8: In chained mode, after the count reaches all ones, the next edge brings every stage back to zero.
- R9: In chained mode, from one falling edge to the next, `taps` either holds its value or increases by exactly one, modulo 2^TAPS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; stages advance on its falling edge |
| rst_n | input | 1 | Active-low reset, sampled on the falling edge |
| test_sel | input | 1 | Mode select, captured only during reset: 1 split, 0 chained |
| taps | output | TAPS | Top TAPS stage outputs, lowest visible stage in bit 0 |
| osc_en | output | 1 | Oscillator enable, low while reset is held |

## Verification
The hardest behaviours to reach from the ports are the first movement of the lowest visible tap in chained mode and the wrap back to zero. At the defaults these need 2^17 and 2^24 falling edges. The bench runs the full-size divider up to the exact edge where the lowest tap first rises. Alongside it, a second instance cut to twelve stages drives all of its taps to ones and then across the wrap. A reset held across several edges while `test_sel` toggles, followed by mode changes after release, shows which sampled value selects the mode and that later changes are ignored.

// File: rtl/div_pkg.sv
// Shared types for the tapped binary divider.
package div_pkg;

    // Stage organisation, fixed at reset.
    typedef enum logic {
        MODE_CHAIN = 1'b0,
        MODE_SPLIT = 1'b1
    } div_mode_e;

endpackage

// File: rtl/div_mode_latch.sv
// Captures the chain organisation from test_sel while reset is held.
// Assumes reset spans at least one falling clock edge; once reset is
// released the captured mode holds regardless of test_sel.
module div_mode_latch
    import div_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      test_sel,
    output div_mode_e mode
);

    // Sample the select only during reset, on the counting edge.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            mode <= test_sel ? MODE_SPLIT : MODE_CHAIN;
        end
    end

endmodule

// File: rtl/div_chain.sv
// The stage register, cut into SECTIONS equal sections. In chained mode
// each section advances on the carry of the one below it. In split mode
// every section advances on every edge. Assumes SECTIONS divides STAGES
// and TAPS <= STAGES. Synchronous active-low clear on the falling edge.
module div_chain #(
    parameter int STAGES   = 24,
    parameter int SECTIONS = 3,
    parameter int TAPS     = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            split,
    output logic [TAPS-1:0] taps
);

    localparam int SECT_W  = STAGES / SECTIONS;
    localparam int TAP_LSB = STAGES - TAPS;

    logic [STAGES-1:0]   stage_q;
    logic [STAGES-1:0]   stage_d;
    logic [SECTIONS-1:0] inc;

    genvar g;
    generate
        for (g = 0; g < SECTIONS; g++) begin : g_sect
            if (g == 0) begin : g_base
                // The lowest section advances on every edge.
                assign inc[g] = 1'b1;
            end else begin : g_upper
                // Upper sections advance on the lower carry, or freely when split.
                assign inc[g] = split | (inc[g-1] & (&stage_q[(g-1)*SECT_W +: SECT_W]));
            end
            // Next value of this section.
            assign stage_d[g*SECT_W +: SECT_W] = inc[g]
                ? stage_q[g*SECT_W +: SECT_W] + SECT_W'(1)
                : stage_q[g*SECT_W +: SECT_W];
        end
    endgenerate

    // Stage register, cleared while reset is held.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    // Only the top stages are visible.
    assign taps = stage_q[TAP_LSB +: TAPS];

endmodule

// File: rtl/binary_divider_taps.sv
// Top of the tapped divider. The mode is fixed during reset. The stage
// chain runs on the falling edge of clk. osc_en follows reset directly,
// so the clock source can be stopped while the block is held.
module binary_divider_taps
    import div_pkg::*;
#(
    parameter int STAGES   = 24,
    parameter int SECTIONS = 3,
    parameter int TAPS     = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            test_sel,
    output logic [TAPS-1:0] taps,
    output logic            osc_en
);

    div_mode_e mode_q;
    logic      split;

    div_mode_latch u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .test_sel (test_sel),
        .mode     (mode_q)
    );

    // Decode the captured mode for the chain.
    assign split = (mode_q == MODE_SPLIT);

    div_chain #(
        .STAGES   (STAGES),
        .SECTIONS (SECTIONS),
        .TAPS     (TAPS)
    ) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .split (split),
        .taps  (taps)
    );

    // Oscillator enabled only while out of reset.
    assign osc_en = rst_n;

endmodule

// File: rtl/divider_checker.sv
// Properties of the tapped divider, sampled on its counting edge.
module divider_checker #(
    parameter int TAPS = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            split,
    input logic [TAPS-1:0] taps,
    input logic            osc_en
);

    logic rst_seen_q;
    logic osc_off_q;

    // Remember whether reset and the oscillator enable were low at the last edge.
    always_ff @(negedge clk) begin
        rst_seen_q <= !rst_n;
        osc_off_q  <= !osc_en;
    end

    // R3: after an edge with reset low, the taps read zero.
    a_r3_reset_clears: assert property (@(negedge clk) rst_seen_q |-> taps == '0);

    // R4: an edge that saw the enable low left the chain cleared.
    a_r4_osc_off_cleared: assert property (@(negedge clk) osc_off_q |-> taps == '0);

    // R7: the mode holds while running.
    a_r7_mode_held: assert property (@(negedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(split));

    // R9: chained taps hold or step by one.
    a_r9_tap_step: assert property (@(negedge clk) disable iff (!rst_n)
        (!split && $past(rst_n)) |->
        (taps == $past(taps) || taps == $past(taps) + TAPS'(1)));

endmodule

bind binary_divider_taps divider_checker #(.TAPS(TAPS)) u_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .split  (split),
    .taps   (taps),
    .osc_en (osc_en)
);

// File: tb/tb_binary_divider_taps.sv
module tb_binary_divider_taps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       test_sel = 1'b1;
    logic [6:0] taps_big;
    logic [6:0] taps_small;
    logic       osc_big;
    logic       osc_small;

    int  checks = 0;
    int  errors = 0;
    longint n = 0;
    bit  mode_now = 1'b1;

    always #10 clk = ~clk;

    binary_divider_taps dut (
        .clk(clk), .rst_n(rst_n), .test_sel(test_sel),
        .taps(taps_big), .osc_en(osc_big)
    );

    binary_divider_taps #(.STAGES(12), .SECTIONS(3), .TAPS(7)) dut_small (
        .clk(clk), .rst_n(rst_n), .test_sel(test_sel),
        .taps(taps_small), .osc_en(osc_small)
    );

    // Reference tap value from the edge count and the mode.
    function automatic logic [6:0] exp_taps(longint cnt, bit sp, int s, int secs, int t);
        longint v = 0;
        int w = s / secs;
        if (!sp) begin
            v = cnt % (longint'(1) << s);
        end else begin
            for (int i = 0; i < secs; i++) begin
                v = v | ((cnt % (longint'(1) << w)) << (i * w));
            end
        end
        return 7'((v >> (s - t)) & ((longint'(1) << t) - 1));
    endfunction

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", tag, act, exp, n);
        end
    endtask

    task automatic check_both(string tag);
        check({tag, " full"}, taps_big, exp_taps(n, mode_now, 24, 3, 7));
        check({tag, " small"}, taps_small, exp_taps(n, mode_now, 12, 3, 7));
    endtask

    // Hold reset over two edges with mode m, check, release on a rising edge.
    task automatic apply_reset(bit m);
        @(posedge clk);
        rst_n = 1'b0;
        test_sel = m;
        repeat (2) @(posedge clk);
        #1;
        check("R3 cleared full", taps_big, 0);
        check("R3 cleared small", taps_small, 0);
        check("R4 enable low", osc_big, 0);
        @(posedge clk);
        rst_n = 1'b1;
        n = 0;
        mode_now = m;
    endtask

    task automatic run(longint len);
        repeat (len) @(posedge clk);
        #1;
        n += len;
    endtask

    localparam int NSEG = 9;
    localparam bit SEG_RST  [NSEG] = '{1, 0, 0, 0, 0, 1, 0, 0, 0};
    localparam bit SEG_MODE [NSEG] = '{1, 1, 1, 1, 1, 0, 0, 0, 0};
    localparam int SEG_LEN  [NSEG] = '{1, 1, 253, 1, 44, 4095, 1, 126975, 1};

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        string tag;
        for (int i = 0; i < NSEG; i++) begin
            if (SEG_RST[i]) apply_reset(SEG_MODE[i]);
            run(SEG_LEN[i]);
            if (i == 0)       tag = "R2 first edge";
            else if (i == 6)  tag = "R8 wrap";
            else if (SEG_MODE[i]) tag = "R5 split";
            else              tag = "R1 chained";
            check_both(tag);
        end
        // R1: lowest visible stage first set at exactly 2^17 edges
        check("R1 stage18 rise", taps_big, 1);
        check("R4 enable high", osc_big, 1);

        // R7: select changed while running is ignored
        test_sel = 1'b1;
        run(3);
        check_both("R7 ignored");

        // R4: enable drops at once, stages clear on the next edge (R3)
        rst_n = 1'b0;
        #1;
        check("R4 enable drop", osc_big, 0);
        check("R4 enable drop small", osc_small, 0);
        @(posedge clk);
        #1;
        check("R3 mid-count clear", taps_big, 0);

        // R6: last value sampled during reset selects the mode
        test_sel = 1'b0;
        @(posedge clk);
        test_sel = 1'b1;
        @(posedge clk);
        rst_n = 1'b1;
        test_sel = 1'b0;
        n = 0;
        mode_now = 1'b1;
        run(2);
        check_both("R6 last sample");
        check("R6 split tap", taps_big, 1);
        run(254);
        check_both("R5 section wrap");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule